// File: doc/BRIEF.md
# Iterative Column-Sum Multi-Operand Adder

This block adds a set of unsigned operands without a carry chain and without an adder tree. It keeps a bank of working registers. The loaded operands fill the first slots, and every clock cycle it performs one iteration. For each bit column it counts how many working registers have a one in that column. The count for column i is shifted left by i places and written into register i, and that bank of shifted counts becomes the operand set for the next iteration.

The arithmetic total of the bank never changes. Iteration stops once every register i is either zero or holds only bit i. At that point bit i of the sum is bit i of register i.

The registers are wide enough to hold the full sum of all operands. A stop rule chosen by parameter either checks that canonical shape or waits for the bank to stop changing. A safety limit ends a run that has not settled within a fixed number of iterations. A host pulses the load strobe with all operands on a flat bus, waits for the one-cycle done pulse, and reads the sum and the number of iterations that were used.

Top module: `mopadd_iter`

## Requirements
- R1: The cycle after `load_i` is sampled high, `busy_o` is 1, `done_o` is 0 and `iter_o` is 0. A load while busy discards the run in progress and starts over with the new operands.
- R2: When `done_o` pulses, `sum_o` equals the arithmetic sum of all operands. Operand k sits in bits [k*OP_W +: OP_W] of `ops_i`, and the sum is SUM_W = OP_W + clog2(N_OPS) bits wide, with no wrap.
- R3: The arithmetic total of the working register bank is unchanged from one cycle to the next unless a load is sampled.
- R4: After at least one iteration, working register i holds no bits below position i, and registers beyond the last column hold zero.
- R5: With the default stop rule, a run ends without iterating when the loaded bank is already canonical, meaning each slot i is zero or exactly 1<<i. A single operand of value 2 takes 1 iteration, and two operands of value 1 take 2 iterations.
- R6: `iter_o` counts the iterations performed and never exceeds MAX_ITER. When MAX_ITER is reached, the run ends with done even if the bank has not settled.
- R7: `done_o` is a single-cycle pulse, and `busy_o` is 0 whenever `done_o` is 1.
- R8: `sum_o` changes only in a cycle in which `done_o` is 1, and it holds its value while idle and during the next run.
- R9: After reset, `busy_o`, `done_o`, `iter_o` and `sum_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load strobe; captures `ops_i` and starts a run |
| ops_i | input | N_OPS*OP_W | Operands, operand k at bits [k*OP_W +: OP_W] |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse when the run ends |
| sum_o | output | SUM_W | Sum of the last finished run |
| iter_o | output | clog2(MAX_ITER+1) | Iterations used by the current or last run |

## Verification
The bench goes after banks that are already canonical at load time. A design that iterated at least once on such a bank would report a nonzero iteration count, and one that tested the wrong bits would never stop. It drives operands that sit in a slot below their own column, such as a single value of 2 or two values of 1, and checks the exact iteration counts. A wrong shift or a wrong column count would show up there as a wrong sum or count. All-ones and top-bit-only operands exercise the widest column counts and the topmost sum bit, where a sum register that is too narrow would truncate. A reload in the middle of a run and a long idle period after done catch a design that mixes state across runs or lets the sum drift.

// File: rtl/mopadd_pkg.sv
package mopadd_pkg;
   // Rule that ends the iteration loop
   typedef enum logic {
      STOP_CANONICAL = 1'b0,  // every register i is zero or exactly bit i
      STOP_STABLE    = 1'b1   // next bank equals the current bank
   } stop_rule_e;
endpackage

// File: rtl/mopadd_colcount.sv
// Population count of one bit column across the working bank.
module mopadd_colcount #(
   parameter int K  = 8,
   parameter int CW = $clog2(K + 1)
) (
   input  logic [K-1:0]  bits_i,
   output logic [CW-1:0] cnt_o
);
   always_comb begin
      cnt_o = '0;
      for (int k = 0; k < K; k++) begin
         cnt_o = cnt_o + CW'(bits_i[k]);
      end
   end
endmodule

// File: rtl/mopadd_step.sv
// One iteration: each column count is shifted to its column and becomes a register.
module mopadd_step #(
   parameter int K = 11,
   parameter int W = 11
) (
   input  logic [K-1:0][W-1:0] cur_i,
   output logic [K-1:0][W-1:0] nxt_o
);
   localparam int CW = $clog2(K + 1);

   for (genvar c = 0; c < W; c++) begin : g_col
      logic [K-1:0]  col;
      logic [CW-1:0] cnt;
      for (genvar k = 0; k < K; k++) begin : g_tap
         assign col[k] = cur_i[k][c];
      end
      mopadd_colcount #(.K(K), .CW(CW)) u_cnt (.bits_i(col), .cnt_o(cnt));
      assign nxt_o[c] = W'(cnt) << c;
   end

   for (genvar j = W; j < K; j++) begin : g_spare
      assign nxt_o[j] = '0;
   end
endmodule

// File: rtl/mopadd_settle.sv
// Detects the canonical shape: register i is zero or holds only bit i.
module mopadd_settle #(
   parameter int K = 11,
   parameter int W = 11
) (
   input  logic [K-1:0][W-1:0] regs_i,
   output logic                canon_o
);
   logic [K-1:0] ok;

   for (genvar i = 0; i < W; i++) begin : g_col
      localparam logic [W-1:0] ONE_HOT = W'(1) << i;
      assign ok[i] = (regs_i[i] == '0) || (regs_i[i] == ONE_HOT);
   end
   for (genvar j = W; j < K; j++) begin : g_spare
      assign ok[j] = (regs_i[j] == '0);
   end

   assign canon_o = &ok;
endmodule

// File: rtl/mopadd_iter.sv
module mopadd_iter #(
   parameter int                     N_OPS    = 8,
   parameter int                     OP_W     = 8,
   parameter int                     MAX_ITER = 32,
   parameter mopadd_pkg::stop_rule_e STOP     = mopadd_pkg::STOP_CANONICAL,
   localparam int                    SUM_W    = OP_W + $clog2(N_OPS),
   localparam int                    ITER_W   = $clog2(MAX_ITER + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load_i,
   input  logic [N_OPS*OP_W-1:0]   ops_i,
   output logic                    busy_o,
   output logic                    done_o,
   output logic [SUM_W-1:0]        sum_o,
   output logic [ITER_W-1:0]       iter_o
);
   import mopadd_pkg::*;

   localparam int W  = SUM_W;
   localparam int K  = (N_OPS > W) ? N_OPS : W;
   localparam int TW = W + $clog2(K) + 1;

   // elaboration-time parameter checks
   if (N_OPS < 2) begin : g_bad_nops
      $error("mopadd_iter: N_OPS must be at least 2");
   end
   if (OP_W < 1) begin : g_bad_opw
      $error("mopadd_iter: OP_W must be at least 1");
   end
   if (MAX_ITER < 1) begin : g_bad_iter
      $error("mopadd_iter: MAX_ITER must be at least 1");
   end

   logic [K-1:0][W-1:0] regs_q, regs_nxt, regs_load;
   logic [W-1:0]        sum_gather;
   logic                settled, finish;

   // operand slots, zero-extended; unused slots cleared
   for (genvar k = 0; k < K; k++) begin : g_load
      if (k < N_OPS) begin : g_op
         assign regs_load[k] = W'(ops_i[k*OP_W +: OP_W]);
      end else begin : g_zero
         assign regs_load[k] = '0;
      end
   end

   mopadd_step #(.K(K), .W(W)) u_step (.cur_i(regs_q), .nxt_o(regs_nxt));

   // stop-rule variant
   if (STOP == STOP_CANONICAL) begin : g_canon
      mopadd_settle #(.K(K), .W(W)) u_settle (.regs_i(regs_q), .canon_o(settled));
   end else begin : g_stable
      assign settled = (regs_nxt == regs_q);
   end

   for (genvar i = 0; i < W; i++) begin : g_sum
      assign sum_gather[i] = regs_q[i][i];
   end

   assign finish = settled || (iter_o == ITER_W'(MAX_ITER));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         regs_q <= '0;
         busy_o <= 1'b0;
         done_o <= 1'b0;
         iter_o <= '0;
         sum_o  <= '0;
      end else begin
         done_o <= 1'b0;
         if (load_i) begin
            regs_q <= regs_load;
            busy_o <= 1'b1;
            iter_o <= '0;
         end else if (busy_o) begin
            if (finish) begin
               busy_o <= 1'b0;
               done_o <= 1'b1;
               sum_o  <= sum_gather;
            end else begin
               regs_q <= regs_nxt;
               iter_o <= iter_o + 1'b1;
            end
         end
      end
   end

   // ---------------- assertions ----------------
   logic [TW-1:0] bank_total;
   logic          bank_shaped;
   always_comb begin
      bank_total  = '0;
      bank_shaped = 1'b1;
      for (int k = 0; k < K; k++) begin
         bank_total = bank_total + TW'(regs_q[k]);
         if (k >= W) begin
            if (regs_q[k] != '0) bank_shaped = 1'b0;
         end else begin
            for (int b = 0; b < W; b++) begin
               if (b < k && regs_q[k][b]) bank_shaped = 1'b0;
            end
         end
      end
   end

   // R1: a load starts a fresh run
   a_r1_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (busy_o && !done_o && iter_o == '0));
   // R3: column-count replacement keeps the bank total
   a_r3_total_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(bank_total));
   // R4: after an iteration, nothing below a register's own column
   a_r4_shape: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && iter_o != '0) |-> bank_shaped);
   // R6: iteration count capped
   a_r6_iter_cap: assert property (@(posedge clk) disable iff (!rst_n)
      iter_o <= ITER_W'(MAX_ITER));
   // R7: done is a pulse and excludes busy
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
   // R8: sum moves only with done
   a_r8_sum_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sum_o) |-> done_o);
endmodule

// File: tb/mopadd_iter_test.sv
`timescale 1ns/1ps
module mopadd_iter_test;
   localparam int N     = 8;
   localparam int OW    = 8;
   localparam int MAXI  = 32;
   localparam int SW    = OW + $clog2(N);
   localparam int IW    = $clog2(MAXI + 1);
   localparam int NV    = 8;

   // stimulus table: operands and expected iteration count (-1: not checked)
   localparam logic [N*OW-1:0] VOPS [NV] = '{
      64'h0000_0000_0000_0000,
      64'h0000_0000_0000_0001,
      64'h0000_0000_0000_0002,
      64'h0000_0000_0000_0101,
      64'h0000_0000_0004_0201,
      64'hFFFF_FFFF_FFFF_FFFF,
      64'h8080_8080_8080_8080,
      64'h0123_4567_89AB_CDEF
   };
   localparam int VITER [NV] = '{0, 0, 1, 2, 0, 2, -1, -1};

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            load_i = 1'b0;
   logic [N*OW-1:0] ops_i = '0;
   logic            busy_o, done_o;
   logic [SW-1:0]   sum_o;
   logic [IW-1:0]   iter_o;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;  // 250 MHz

   mopadd_iter #(.N_OPS(N), .OP_W(OW), .MAX_ITER(MAXI)) uut (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .ops_i(ops_i),
      .busy_o(busy_o), .done_o(done_o), .sum_o(sum_o), .iter_o(iter_o));

   task automatic check(input string req, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int ref_sum(input logic [N*OW-1:0] v);
      int s = 0;
      for (int k = 0; k < N; k++) s += int'(v[k*OW +: OW]);
      return s;
   endfunction

   task automatic wait_done(output int ok);
      int cyc = 0;
      while (!done_o && cyc < 200) begin
         @(negedge clk);
         cyc++;
      end
      ok = done_o ? 1 : 0;
   endtask

   // load, wait for done, check sum (R2) and optionally iteration count (R5)
   task automatic run(input logic [N*OW-1:0] v, input int exp_iter);
      int ok;
      @(negedge clk);
      load_i = 1'b1;
      ops_i  = v;
      @(negedge clk);
      load_i = 1'b0;
      check("R1 busy after load", busy_o, 1);
      check("R1 iter cleared", iter_o, 0);
      wait_done(ok);
      check("R7 done reached", ok, 1);
      check("R7 busy low at done", busy_o, 0);
      check("R2 sum", sum_o, ref_sum(v));
      if (exp_iter >= 0) check("R5 iteration count", iter_o, exp_iter);
      else check("R6 under cap", (iter_o < MAXI) ? 1 : 0, 1);
      @(negedge clk);
      check("R7 done single pulse", done_o, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [N*OW-1:0] rv;
      logic [SW-1:0]   held;
      int              ok;
      repeat (3) @(negedge clk);
      // R9: reset state
      check("R9 busy at reset", busy_o, 0);
      check("R9 done at reset", done_o, 0);
      check("R9 iter at reset", iter_o, 0);
      check("R9 sum at reset", sum_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) run(VOPS[i], VITER[i]);

      for (int i = 0; i < 20; i++) begin
         rv = {$urandom(), $urandom()};
         run(rv, -1);
      end

      // R8: sum holds while idle
      held = sum_o;
      repeat (10) @(negedge clk);
      check("R8 sum held idle", sum_o, held);
      check("R8 idle not busy", busy_o, 0);

      // R1: reload in the middle of a run restarts it; R8 sum held while busy
      @(negedge clk);
      load_i = 1'b1;
      ops_i  = '1;
      @(negedge clk);
      ops_i  = 64'h0000_0000_0000_0101;
      @(negedge clk);
      load_i = 1'b0;
      check("R1 restart iter", iter_o, 0);
      check("R8 sum held busy", sum_o, held);
      wait_done(ok);
      check("R1 restart done", ok, 1);
      check("R1 restart sum", sum_o, 2);
      check("R5 restart iterations", iter_o, 2);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule